// File: doc/BRIEF.md
# Control Endpoint Command and Status Register

This block holds the eight-bit command and status word of a USB device controller's control endpoint. Firmware writes and reads it over a simple register port. The packet engine reports events to it through single-cycle strobes: a packet arrived, a packet left, a STALL handshake left, the setup phase was cut short, and the status stage finished. Each bit follows its own access rule. Some bits are set by software and cleared by hardware. Some are set by hardware and cleared by software. Two bits are write-only strobes that clear a neighbouring status bit and always read back as zero.

The block drives a STALL request level and a transmit-ready level to the packet engine. It also drives a one-cycle FIFO flush pulse and a one-cycle interrupt pulse. A write-protect input makes the register ignore bus writes. When a hardware set and a software clear hit the same bit in the same cycle, the set wins, so no event is lost. When a software set and a hardware clear meet, the new software request wins.

Top module: `ep0_ctl_reg`

## Requirements
- R1: After reset, all readable bits are 0, and stall_req, tx_ready, fifo_flush and irq are all low.
- R2: Bits 7 and 6 always read as 0. A write with bit 7 set clears setup-end (bit 4). A write with bit 6 set clears rx-ready (bit 0).
- R3: A write with bit 5 set sets send-stall, and stall_req follows bit 5. The stall_sent strobe clears send-stall. A write with bit 5 at 0 leaves it unchanged. A write of 1 in the same cycle as the strobe leaves it set.
- R4: The setup_end strobe sets bit 4 only while data-end (bit 3) is 0, and is ignored while data-end is 1. An accepted strobe produces a one-cycle fifo_flush pulse in the cycle after the strobe, together with the bit becoming visible.
- R5: A write with bit 3 set sets data-end. A write with bit 3 at 0 leaves it unchanged. The status_done strobe clears it. A software set in the same cycle wins.
- R6: The stall_sent strobe sets sent-stall (bit 2). A write with bit 2 at 0 clears it. A write with bit 2 at 1 leaves it unchanged.
- R7: A write with bit 1 set sets tx-packet-ready, and tx_ready follows bit 1. The tx_done strobe clears it. A software set in the same cycle wins.
- R8: The rx_pkt strobe sets rx-ready (bit 0). The value written to bit 0 has no effect. With RX_IRQ_EN=1, each rx_pkt strobe produces a one-cycle irq pulse in the next cycle.
- R9: While wr_lock is high, bus writes change no bit.
- R10: When a hardware set and a software clear of the same bit fall in one cycle, the bit ends up set. This applies to bits 4, 2 and 0.
- R11: irq is high for exactly the one cycle after an accepted setup_end strobe or an enabled rx_pkt strobe, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write enable |
| bus_wdata | input | 8 | Write data |
| wr_lock | input | 1 | Write protect; blocks writes while high |
| bus_rdata | output | 8 | Current register value |
| ev_rx_pkt | input | 1 | Strobe: packet received |
| ev_tx_done | input | 1 | Strobe: packet transmitted |
| ev_stall_sent | input | 1 | Strobe: STALL handshake transmitted |
| ev_setup_end | input | 1 | Strobe: control transfer ended early |
| ev_status_done | input | 1 | Strobe: status stage complete |
| stall_req | output | 1 | STALL request level |
| tx_ready | output | 1 | Transmit packet ready level |
| fifo_flush | output | 1 | One-cycle FIFO flush pulse |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The hardest situations to reach are collisions: a strobe lands in the same cycle as a bus write that sets or clears the same bit, and the early-end strobe arrives while data-end is already set. The stimulus first preloads the register into a chosen mix of set and clear bits. It then applies every one of the 32 strobe combinations together with writes that clear everything, set everything, hit only the clearing strobes, or hit only the software-set bits. The expected word and pulses are computed in the bench from the per-bit rules. Full sweeps of all 256 write values, with the lock both open and closed, cover the access rule of every bit.

// File: rtl/ep0_ctl_reg.sv
module ep0_ctl_reg #(
  parameter bit RX_IRQ_EN = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_we,
  input  logic [7:0] bus_wdata,
  input  logic       wr_lock,
  output logic [7:0] bus_rdata,
  input  logic       ev_rx_pkt,
  input  logic       ev_tx_done,
  input  logic       ev_stall_sent,
  input  logic       ev_setup_end,
  input  logic       ev_status_done,
  output logic       stall_req,
  output logic       tx_ready,
  output logic       fifo_flush,
  output logic       irq
);

  logic stall_q, setup_q, dend_q, sstall_q, tx_q, rx_q;
  logic wr, se_acc, rx_irq;

  assign wr     = bus_we & ~wr_lock;
  assign se_acc = ev_setup_end & ~dend_q;
  assign rx_irq = ev_rx_pkt & RX_IRQ_EN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stall_q    <= 1'b0;
      setup_q    <= 1'b0;
      dend_q     <= 1'b0;
      sstall_q   <= 1'b0;
      tx_q       <= 1'b0;
      rx_q       <= 1'b0;
      fifo_flush <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (wr && bus_wdata[5])      stall_q <= 1'b1;
      else if (ev_stall_sent)      stall_q <= 1'b0;

      if (se_acc)                  setup_q <= 1'b1;
      else if (wr && bus_wdata[7]) setup_q <= 1'b0;

      if (wr && bus_wdata[3])      dend_q <= 1'b1;
      else if (ev_status_done)     dend_q <= 1'b0;

      if (ev_stall_sent)           sstall_q <= 1'b1;
      else if (wr && !bus_wdata[2]) sstall_q <= 1'b0;

      if (wr && bus_wdata[1])      tx_q <= 1'b1;
      else if (ev_tx_done)         tx_q <= 1'b0;

      if (ev_rx_pkt)               rx_q <= 1'b1;
      else if (wr && bus_wdata[6]) rx_q <= 1'b0;

      fifo_flush <= se_acc;
      irq        <= se_acc | rx_irq;
    end
  end

  assign bus_rdata = {2'b00, stall_q, setup_q, dend_q, sstall_q, tx_q, rx_q};
  assign stall_req = stall_q;
  assign tx_ready  = tx_q;

  // R8
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_pkt |=> bus_rdata[0]);

  // R6
  sstall_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stall_sent |=> bus_rdata[2]);

  // R4
  flush_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |-> bus_rdata[4]);

  // R9
  lock_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && wr_lock && !ev_tx_done) |=> (tx_ready == $past(tx_ready)));

  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(ev_rx_pkt || ev_setup_end));

  // R3
  stall_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stall_sent && !(bus_we && !wr_lock && bus_wdata[5])) |=> !stall_req);

endmodule

// File: tb/tb_ep0_ctl_reg.sv
module tb_ep0_ctl_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0, wr_lock = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic ev_rx_pkt = 0, ev_tx_done = 0, ev_stall_sent = 0, ev_setup_end = 0, ev_status_done = 0;
  logic stall_req, tx_ready, fifo_flush, irq;

  int checks = 0, fails = 0;
  logic [5:0] s = '0;
  logic exp_flush = 0, exp_irq = 0;

  always #10 clk = ~clk;

  ep0_ctl_reg #(.RX_IRQ_EN(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_wdata(bus_wdata),
    .wr_lock(wr_lock), .bus_rdata(bus_rdata), .ev_rx_pkt(ev_rx_pkt),
    .ev_tx_done(ev_tx_done), .ev_stall_sent(ev_stall_sent),
    .ev_setup_end(ev_setup_end), .ev_status_done(ev_status_done),
    .stall_req(stall_req), .tx_ready(tx_ready), .fifo_flush(fifo_flush), .irq(irq)
  );

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic compare(input string tag);
    chk(tag, "rdata", bus_rdata, {2'b00, s});
    chk(tag, "stall_req", {7'd0, stall_req}, {7'd0, s[5]});
    chk(tag, "tx_ready", {7'd0, tx_ready}, {7'd0, s[1]});
    chk(tag, "fifo_flush", {7'd0, fifo_flush}, {7'd0, exp_flush});
    chk(tag, "irq", {7'd0, irq}, {7'd0, exp_irq});
  endtask

  // ev: [0] rx_pkt, [1] tx_done, [2] stall_sent, [3] setup_end, [4] status_done
  task automatic step(input logic we, input logic [7:0] wd, input logic lock,
                      input logic [4:0] ev, input string tag);
    logic w, acc;
    logic [5:0] n;
    w   = we & ~lock;
    acc = ev[3] & ~s[3];
    n[5] = (w & wd[5]) ? 1'b1 : (ev[2] ? 1'b0 : s[5]);
    n[4] = acc ? 1'b1 : ((w & wd[7]) ? 1'b0 : s[4]);
    n[3] = (w & wd[3]) ? 1'b1 : (ev[4] ? 1'b0 : s[3]);
    n[2] = ev[2] ? 1'b1 : ((w & ~wd[2]) ? 1'b0 : s[2]);
    n[1] = (w & wd[1]) ? 1'b1 : (ev[1] ? 1'b0 : s[1]);
    n[0] = ev[0] ? 1'b1 : ((w & wd[6]) ? 1'b0 : s[0]);
    bus_we = we; bus_wdata = wd; wr_lock = lock;
    {ev_status_done, ev_setup_end, ev_stall_sent, ev_tx_done, ev_rx_pkt} = ev;
    @(posedge clk);
    s = n; exp_flush = acc; exp_irq = acc | ev[0];
    @(negedge clk);
    bus_we = 0; bus_wdata = 0; wr_lock = 0;
    {ev_status_done, ev_setup_end, ev_stall_sent, ev_tx_done, ev_rx_pkt} = '0;
    compare(tag);
  endtask

  function automatic logic [7:0] pat(input int p);
    case (p)
      0: return 8'hC0;
      1: return 8'h2A;
      2: return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  logic done = 0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R2 R3 R5 R6 R7 R8: every write value against a fully loaded register
    for (int w = 0; w < 256; w++) begin
      step(1, 8'h2E, 0, 5'b01101, "R6 preload");
      step(1, w[7:0], 0, 5'b00000, "R2 R3 R5 R6 R7 R8");
      step(0, 8'h00, 0, 5'b10110, "R3 R5 R7 clear");
    end

    // R9: every write value with the lock closed
    for (int w = 0; w < 256; w++) begin
      step(1, 8'h2E, 0, 5'b01101, "R9 preload");
      step(1, w[7:0], 1, 5'b00000, "R9");
    end

    // R4 R10 R11: all strobe combinations against write patterns and preloads
    for (int e = 0; e < 32; e++) begin
      for (int p = 0; p < 4; p++) begin
        step(1, (p[0] ? 8'h2E : 8'h26), 0, (p[1] ? 5'b01101 : 5'b00100), "R4 preload");
        step(1, pat(p), 0, e[4:0], "R4 R10 R11");
        step(0, 8'h00, 0, 5'b00000, "R11 idle");
        step(1, 8'hC4, 0, 5'b00000, "R2 clear");
        step(0, 8'h00, 0, e[4:0], "R4 R8 strobe only");
      end
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule